// File: doc/BRIEF.md
# Channel Status and User Bit Block Capture

This block gathers the per-subframe side-channel bits of a two-channel serial audio stream into complete 192-bit blocks. For every accepted subframe it receives one channel-status bit and one user bit, together with the index of the channel the subframe belongs to and a flag that marks the first frame of a block. The block keeps a private fill buffer for each channel and each kind of bit. Only when a full block of 192 bits has been gathered does it copy the block into the readable store, so software never sees a half-written block.

Each readable store holds 192 bits and is read as six 32-bit words through a combinational address/data port. For each channel the block pulses one-cycle flags when a block starts, when a block completes, and when the completed channel-status block differs from the one it replaces. Preamble detection and biphase decoding happen upstream. The bus interface lives elsewhere.

Top module: `cs_block_capture`

## Requirements
- R1: After reset all readable words are zero and all event outputs are low.
- R2: A channel that has not yet received a subframe carrying the start flag ignores its subframes. Nothing is stored for it and no event is raised for it.
- R3: An accepted subframe with `sf_sob` high writes its bits at position 0 of its channel's fill buffers and restarts alignment. `evt_start[ch]` pulses in the following cycle.
- R4: Each further subframe of an aligned channel fills the next position. Position k lands in word k/32, bit k%32, so bits [7:0] of a word hold the first byte of that word. When position 191 is written, both readable stores of that channel take the completed block and `evt_end[ch]` pulses in the following cycle.
- R5: The readable stores change only together with an `evt_end` pulse of their channel. A partly filled block is never readable.
- R6: `evt_cs_chg[ch]` pulses together with `evt_end[ch]` only when the completed status block differs from the status block stored before it. After reset, the stored block is all zeros.
- R7: A start flag in the middle of a block discards the partial block and restarts filling at position 0.
- R8: After position 191 the count wraps to 0. The next block is gathered even if no start flag arrives.
- R9: `rd_addr[4]` selects the channel, `rd_addr[3]` selects status (0) or user data (1), and `rd_addr[2:0]` selects word 0 to 5. Words 6 and 7 read as zero. `rd_data` follows `rd_addr` in the same cycle.
- R10: The two channels fill, complete and flag independently, including when their subframes are interleaved.
- R11: Cycles with `sf_valid` low have no effect, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sf_valid | input | 1 | One-cycle strobe per decoded subframe |
| sf_chan | input | 1 | Channel of the subframe |
| sf_sob | input | 1 | Subframe is the first of a block |
| sf_cbit | input | 1 | Channel-status bit of the subframe |
| sf_ubit | input | 1 | User bit of the subframe |
| rd_addr | input | 5 | Read address {channel, kind, word} |
| rd_data | output | 32 | Selected 32-bit word |
| evt_start | output | 2 | Per-channel block-start pulse |
| evt_end | output | 2 | Per-channel block-complete pulse |
| evt_cs_chg | output | 2 | Per-channel status-changed pulse |

## Verification
The event flags are registered. Each is due exactly one clock after the rising edge that accepts the triggering subframe. The readable stores switch on that same edge, so a word read through the combinational port shows the new block in the cycle its `evt_end` is high. The bench steps a behavioural model at every rising edge on the inputs it has just driven. It compares all event bits and the word at a rotating read address on every falling edge, when each result is settled. The read address is changed only after that comparison.

// File: rtl/cs_cap_pkg.sv
package cs_cap_pkg;
  typedef enum logic {
    KIND_STATUS = 1'b0,
    KIND_USER   = 1'b1
  } store_kind_e;
endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/cs_chan_acc.sv
module cs_chan_acc #(
  parameter int BLK_BITS = 192,
  localparam int CW = $clog2(BLK_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sub_en,
  input  logic                sub_sob,
  input  logic                cbit,
  input  logic                ubit,
  output logic [BLK_BITS-1:0] cs_q,
  output logic [BLK_BITS-1:0] ud_q,
  output logic                ev_start_q,
  output logic                ev_end_q,
  output logic                ev_chg_q
);
  localparam logic [CW-1:0] LAST_POS = CW'(BLK_BITS - 1);

  logic                aligned_q, aligned_d;
  logic [CW-1:0]       cnt_q, cnt_d, idx;
  logic [BLK_BITS-1:0] cs_sh_q, cs_sh_d, ud_sh_q, ud_sh_d;
  logic [BLK_BITS-1:0] cs_d, ud_d;
  logic                take, last, ev_start_d, ev_end_d, ev_chg_d;

  // next-state logic
  always_comb begin
    idx       = sub_sob ? '0 : cnt_q;
    take      = sub_en && (sub_sob || aligned_q);
    last      = take && (idx == LAST_POS);
    cs_sh_d   = cs_sh_q;
    ud_sh_d   = ud_sh_q;
    if (take) begin
      cs_sh_d[idx] = cbit;
      ud_sh_d[idx] = ubit;
    end
    cnt_d = cnt_q;
    if (take) cnt_d = last ? '0 : idx + 1'b1;
    aligned_d  = aligned_q | (sub_en && sub_sob);
    cs_d       = last ? cs_sh_d : cs_q;
    ud_d       = last ? ud_sh_d : ud_q;
    ev_start_d = sub_en && sub_sob;
    ev_end_d   = last;
    ev_chg_d   = last && (cs_sh_d != cs_q);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aligned_q  <= 1'b0;
      cnt_q      <= '0;
      cs_sh_q    <= '0;
      ud_sh_q    <= '0;
      cs_q       <= '0;
      ud_q       <= '0;
      ev_start_q <= 1'b0;
      ev_end_q   <= 1'b0;
      ev_chg_q   <= 1'b0;
    end else begin
      aligned_q  <= aligned_d;
      ev_start_q <= ev_start_d;
      ev_end_q   <= ev_end_d;
      ev_chg_q   <= ev_chg_d;
      if (take) begin
        cnt_q   <= cnt_d;
        cs_sh_q <= cs_sh_d;
        ud_sh_q <= ud_sh_d;
      end
      if (last) begin
        cs_q <= cs_d;
        ud_q <= ud_d;
      end
    end
  end

  // R4: the fill position never leaves the block
  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_POS);
  // R4 / R8: a completed block leaves the count wrapped to zero
  assert_wrap_after_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_end_q |-> (cnt_q == '0));
  // R5: readable stores only move with a block-end pulse
  assert_store_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_end_q |-> ($stable(cs_q) && $stable(ud_q)));
  // R6: a change flag never appears without a block end
  assert_chg_with_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_chg_q |-> ev_end_q);
  // R3: a start pulse follows an accepted start subframe
  assert_start_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start_q |-> $past(sub_en && sub_sob));
  // R2: an unaligned channel holds its count at zero
  assert_unaligned_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !aligned_q |-> (cnt_q == '0 && !ev_end_q));
endmodule

// File: rtl/cs_read_mux.sv
module cs_read_mux
  import cs_cap_pkg::*;
#(
  parameter int NCH      = 2,
  parameter int BLK_BITS = 192,
  parameter int WORD_W   = 32,
  localparam int NWORDS  = BLK_BITS / WORD_W,
  localparam int CHB     = $clog2(NCH),
  localparam int WB      = $clog2(NWORDS),
  localparam int AW      = CHB + 1 + WB
) (
  input  logic [NCH-1:0][BLK_BITS-1:0] cs_all,
  input  logic [NCH-1:0][BLK_BITS-1:0] ud_all,
  input  logic [AW-1:0]                addr,
  output logic [WORD_W-1:0]            data
);
  logic [CHB-1:0] sel_ch;
  store_kind_e    sel_kind;
  logic [WB-1:0]  sel_word;

  always_comb begin
    sel_ch   = addr[AW-1 -: CHB];
    sel_kind = store_kind_e'(addr[WB]);
    sel_word = addr[WB-1:0];
    data     = '0;
    for (int c = 0; c < NCH; c++) begin
      for (int w = 0; w < NWORDS; w++) begin
        if (int'(sel_ch) == c && int'(sel_word) == w) begin
          data = (sel_kind == KIND_USER) ? ud_all[c][w*WORD_W +: WORD_W]
                                         : cs_all[c][w*WORD_W +: WORD_W];
        end
      end
    end
  end
endmodule

// File: rtl/cs_block_capture.sv
module cs_block_capture #(
  parameter int NCH      = 2,
  parameter int BLK_BITS = 192,
  parameter int WORD_W   = 32,
  localparam int NWORDS  = BLK_BITS / WORD_W,
  localparam int CHB     = $clog2(NCH),
  localparam int WB      = $clog2(NWORDS),
  localparam int AW      = CHB + 1 + WB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sf_valid,
  input  logic [CHB-1:0]    sf_chan,
  input  logic              sf_sob,
  input  logic              sf_cbit,
  input  logic              sf_ubit,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic [NCH-1:0]    evt_start,
  output logic [NCH-1:0]    evt_end,
  output logic [NCH-1:0]    evt_cs_chg
);
  logic                         srst_n;
  logic [NCH-1:0][BLK_BITS-1:0] cs_all, ud_all;

  rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit;
    assign hit = sf_valid && (int'(sf_chan) == g);
    cs_chan_acc #(.BLK_BITS(BLK_BITS)) u_acc (
      .clk        (clk),
      .rst_n      (srst_n),
      .sub_en     (hit),
      .sub_sob    (sf_sob),
      .cbit       (sf_cbit),
      .ubit       (sf_ubit),
      .cs_q       (cs_all[g]),
      .ud_q       (ud_all[g]),
      .ev_start_q (evt_start[g]),
      .ev_end_q   (evt_end[g]),
      .ev_chg_q   (evt_cs_chg[g])
    );
  end

  cs_read_mux #(.NCH(NCH), .BLK_BITS(BLK_BITS), .WORD_W(WORD_W)) u_rd (
    .cs_all (cs_all),
    .ud_all (ud_all),
    .addr   (rd_addr),
    .data   (rd_data)
  );

  // R9: word slots past the block read as zero
  assert_pad_words_zero_R9: assert property (@(posedge clk) disable iff (!srst_n)
    (int'(rd_addr[WB-1:0]) >= NWORDS) |-> (rd_data == '0));
  // R10: each event vector only carries bits of channels that can complete
  assert_chg_subset_R10: assert property (@(posedge clk) disable iff (!srst_n)
    ((evt_cs_chg & ~evt_end) == '0));
endmodule

// File: tb/sim_cs_block_capture.sv
module sim_cs_block_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sf_valid = 1'b0, sf_chan = 1'b0, sf_sob = 1'b0;
  logic        sf_cbit = 1'b0, sf_ubit = 1'b0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [1:0]  evt_start, evt_end, evt_cs_chg;

  always #2 clk = ~clk;

  cs_block_capture u0 (
    .clk(clk), .rst_n(rst_n), .sf_valid(sf_valid), .sf_chan(sf_chan),
    .sf_sob(sf_sob), .sf_cbit(sf_cbit), .sf_ubit(sf_ubit),
    .rd_addr(rd_addr), .rd_data(rd_data), .evt_start(evt_start),
    .evt_end(evt_end), .evt_cs_chg(evt_cs_chg)
  );

  int vectors = 0, miscompares = 0, cycles = 0;
  bit running = 0, done = 0;
  string tag = "R1";

  // behavioural model
  int         m_cnt[2];
  bit         m_al[2];
  bit [191:0] m_shc[2], m_shu[2], m_stc[2], m_stu[2];
  bit [1:0]   m_es, m_ee, m_ec;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_cnt[c] = 0; m_al[c] = 0;
        m_shc[c] = '0; m_shu[c] = '0; m_stc[c] = '0; m_stu[c] = '0;
      end
      m_es = 0; m_ee = 0; m_ec = 0;
    end else begin
      m_es = 0; m_ee = 0; m_ec = 0;
      if (sf_valid) begin
        int c;
        int p;
        c = int'(sf_chan);
        p = -1;
        if (sf_sob) begin
          p = 0; m_al[c] = 1; m_es[c] = 1;
        end else if (m_al[c]) begin
          p = m_cnt[c];
        end
        if (p >= 0) begin
          m_shc[c][p] = sf_cbit;
          m_shu[c][p] = sf_ubit;
          if (p == 191) begin
            m_ee[c] = 1;
            m_ec[c] = (m_shc[c] != m_stc[c]);
            m_stc[c] = m_shc[c];
            m_stu[c] = m_shu[c];
            m_cnt[c] = 0;
          end else begin
            m_cnt[c] = p + 1;
          end
        end
      end
    end
  end

  function automatic bit [31:0] exp_word(bit [4:0] a);
    int c, w;
    c = int'(a[4]);
    w = int'(a[2:0]);
    if (w > 5) return '0;
    return a[3] ? m_stu[c][w*32 +: 32] : m_stc[c][w*32 +: 32];
  endfunction

  // compare every clock at the falling edge, then advance the read address
  always @(negedge clk) begin
    if (running) begin
      vectors++;
      if (evt_start !== m_es) begin
        miscompares++;
        $display("FAIL R3 (%s) evt_start actual=%b expected=%b", tag, evt_start, m_es);
      end
      if (evt_end !== m_ee) begin
        miscompares++;
        $display("FAIL R4 (%s) evt_end actual=%b expected=%b", tag, evt_end, m_ee);
      end
      if (evt_cs_chg !== m_ec) begin
        miscompares++;
        $display("FAIL R6 (%s) evt_cs_chg actual=%b expected=%b", tag, evt_cs_chg, m_ec);
      end
      if (rd_data !== exp_word(rd_addr)) begin
        miscompares++;
        $display("FAIL R9 (%s) addr=%0d rd_data actual=%h expected=%h",
                 tag, rd_addr, rd_data, exp_word(rd_addr));
      end
      rd_addr <= rd_addr + 5'd1;
    end
  end

  task automatic send(input bit ch, input bit sob, input bit c, input bit u);
    @(negedge clk);
    sf_valid = 1; sf_chan = ch; sf_sob = sob; sf_cbit = c; sf_ubit = u;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sf_valid = 0;
      sf_chan = $urandom; sf_sob = $urandom; sf_cbit = $urandom; sf_ubit = $urandom;
    end
  endtask

  task automatic send_block(input bit [191:0] c0, input bit [191:0] u0v,
                            input bit [191:0] c1, input bit [191:0] u1v,
                            input bit use_sob, input int gap, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      send(0, use_sob && i == 0, c0[i], u0v[i]);
      send(1, use_sob && i == 0, c1[i], u1v[i]);
      if (gap > 0) idle(gap);
    end
    idle(1);
  endtask

  function automatic bit [191:0] rnd192();
    bit [191:0] v;
    for (int k = 0; k < 6; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    bit [191:0] ca, cb, ua, ub, uc, ud;
    ca = rnd192(); cb = rnd192(); ua = rnd192(); ub = rnd192();
    uc = rnd192(); ud = rnd192();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1: explicit reset-state check, then a full address sweep
    vectors++;
    if (evt_start !== 0 || evt_end !== 0 || evt_cs_chg !== 0 || rd_data !== 0) begin
      miscompares++;
      $display("FAIL R1 outputs after reset actual=%b%b%b/%h expected=000000/0",
               evt_start, evt_end, evt_cs_chg, rd_data);
    end
    running = 1;
    tag = "R1"; idle(34);
    tag = "R2"; send_block(ca, ua, cb, ub, 0, 0, 20);
    tag = "R11"; idle(40);
    tag = "R10"; send_block(ca, ua, cb, ub, 1, 0, 192);
    tag = "R6"; send_block(ca, uc, cb, ud, 1, 0, 192);
    cb[191] = ~cb[191];
    tag = "R6"; send_block(ca, ua, cb, ub, 1, 0, 192);
    tag = "R7"; send_block(cb, ud, ca, uc, 1, 0, 100);
    send_block(ud, ca, uc, cb, 1, 0, 192);
    tag = "R8"; send_block(ua, ub, uc, ud, 0, 0, 192);
    tag = "R5"; send_block(ca, cb, ua, ub, 0, 1, 192);
    tag = "R4"; idle(40);
    done = 1;
  end

  initial begin
    while (!done && cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=%0d cycles expected=finish", cycles);
    end
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule